// File: doc/BRIEF.md
# Big-Integer Operand Range Checker

This block screens four big-integer operands of a signature check before the arithmetic engine is started. It verifies that both coordinates of a public key lie below the field prime, and that both signature halves are nonzero and below the group order. Operands sit in a byte-wide memory with the most significant byte at the lowest address. The checker fetches them one byte per cycle through a read port with a latency of one cycle. The two bounds arrive as wide input vectors, each with a bit length that sets how many of its bytes count.

A single start pulse runs the four checks in a fixed order. The block stops at the first check that fails, then reports a pass flag and a code that names the failing check. Operands and bounds may have different byte lengths. The shorter of the two is extended with zero bytes at its high end, so a long operand with leading zeros is still accepted.

Top module: `bigint_range_checker`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, pass and mem_rd_en are all 0.
- R2: A value is less than a bound only when the first byte that differs, scanning from the most significant byte down, is smaller in the value. A value equal to its bound is not less.
- R3: When the value and the bound have different byte lengths, the missing high-order bytes of the shorter one count as zero.
- R4: The bound byte count is the bound bit length divided by 8, rounded up. Byte i of p_val or n_val (bits 8i+7..8i) has weight 256^i, and bytes at or above the byte count are ignored.
- R5: Public-key X and Y each pass when strictly less than p. Zero is allowed.
- R6: Signature r and s each pass only when nonzero and strictly less than n. A zero-length operand counts as zero.
- R7: Checks run in the order X (code 0), Y (code 1), r (code 2), s (code 3) and stop at the first failure. fail_code gives the failing check. On overall pass, pass=1 and fail_code=0.
- R8: Each check lasts max(operand bytes, bound bytes)+1 cycles. busy covers exactly the checks that run. done is a one-cycle pulse in the first cycle where busy is low again.
- R9: A read of operand byte j (0 = most significant) uses address base+j, and its data is used in the next cycle. Only bytes inside the operand are read, one read per byte per check that runs.
- R10: A start pulse while busy has no effect on the result or the timing.
- R11: pass and fail_code hold their values after done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run when idle |
| x_base | input | ADDR_W | Address of X's most significant byte |
| x_len | input | LEN_W | Byte length of X |
| y_base | input | ADDR_W | Address of Y's most significant byte |
| y_len | input | LEN_W | Byte length of Y |
| r_base | input | ADDR_W | Address of r's most significant byte |
| r_len | input | LEN_W | Byte length of r |
| s_base | input | ADDR_W | Address of s's most significant byte |
| s_len | input | LEN_W | Byte length of s |
| p_bits | input | BITS_W | Bit length of the prime bound |
| n_bits | input | BITS_W | Bit length of the order bound |
| p_val | input | MAXB*8 | Prime bound, byte 0 least significant |
| n_val | input | MAXB*8 | Order bound, byte 0 least significant |
| mem_rd_en | output | 1 | Operand byte read request |
| mem_rd_addr | output | ADDR_W | Operand byte address |
| mem_rd_data | input | 8 | Read data, one cycle after the request |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | All four checks passed |
| fail_code | output | 2 | Index of the failing check |

## Verification
A compare flag that latches on the wrong byte, or a zero flag that misses a byte, shows up as a wrong pass or fail_code at the end of the affected check. That happens within max-length+1 cycles of the faulty byte. An error in the scan counter or the check index changes how long busy stays high and how many bytes are read, which the run length and read count expose as soon as done pulses. A mis-wired bound byte selection shows up only when the bound's top bytes decide the compare, so cases where the rounded-up length and the ignored extra bytes matter are covered on purpose.

// File: rtl/rc_pkg.sv
package rc_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } rc_state_e;

  // Number of whole bytes needed to hold a value of the given bit length.
  function automatic int unsigned rc_bytes_of_bits(input int unsigned bits);
    return (bits + 32'd7) / 32'd8;
  endfunction

  // Span of one compare: the longer of value and bound.
  function automatic int unsigned rc_span(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Verdict rule for one check: the signature checks also demand a nonzero value.
  function automatic logic rc_accept(input logic less, input logic nonzero, input logic need_nz);
    return less && (nonzero || !need_nz);
  endfunction

endpackage

// File: rtl/rc_seq.sv
module rc_seq
  import rc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [3:0][ADDR_W-1:0] base_i,
  input  logic [3:0][LEN_W-1:0]  len_i,
  input  logic [3:0][LEN_W-1:0]  span_i,
  input  logic                   ok_i,
  output logic                   busy_o,
  output logic                   verdict_o,
  output logic [1:0]             chk_o,
  output logic                   rd_en_o,
  output logic [ADDR_W-1:0]      rd_addr_o,
  output logic                   vld_q_o,
  output logic                   real_q_o,
  output logic [LEN_W-1:0]       sig_q_o,
  output logic                   done_o,
  output logic                   pass_o,
  output logic [1:0]             code_o
);

  rc_state_e         st_q;
  logic [1:0]        chk_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              vld_q, real_q, done_q, pass_q;
  logic [LEN_W-1:0]  sig_q;
  logic [1:0]        code_q;

  logic [LEN_W-1:0]  span_c, len_c, sig_c;
  logic [ADDR_W-1:0] base_c;
  logic              issue_c, inside_c, verdict_c, last_c;

  assign span_c    = span_i[chk_q];
  assign len_c     = len_i[chk_q];
  assign base_c    = base_i[chk_q];
  assign issue_c   = (st_q == ST_SCAN) && (cnt_q < span_c);
  assign sig_c     = span_c - cnt_q - LEN_W'(1);
  assign inside_c  = sig_c < len_c;
  assign verdict_c = (st_q == ST_SCAN) && (cnt_q == span_c);
  assign last_c    = (chk_q == 2'd3);

  // Byte j of the operand (0 = most significant) sits at base + j,
  // and j = len - 1 - significance = len - span + cnt.
  assign rd_addr_o = base_c + ADDR_W'(len_c) - ADDR_W'(span_c) + ADDR_W'(cnt_q);
  assign rd_en_o   = issue_c && inside_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      chk_q  <= 2'd0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      real_q <= 1'b0;
      sig_q  <= '0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      code_q <= 2'd0;
    end else begin
      done_q <= 1'b0;
      vld_q  <= issue_c;
      real_q <= issue_c && inside_c;
      sig_q  <= sig_c;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q   <= ST_SCAN;
            chk_q  <= 2'd0;
            cnt_q  <= '0;
            pass_q <= 1'b0;
            code_q <= 2'd0;
          end
        end
        default: begin
          if (verdict_c) begin
            if (!ok_i || last_c) begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              pass_q <= ok_i;
              code_q <= ok_i ? 2'd0 : chk_q;
            end else begin
              chk_q <= chk_q + 2'd1;
              cnt_q <= '0;
            end
          end else if (issue_c) begin
            cnt_q <= cnt_q + LEN_W'(1);
          end
        end
      endcase
    end
  end

  assign busy_o    = (st_q == ST_SCAN);
  assign verdict_o = verdict_c;
  assign chk_o     = chk_q;
  assign vld_q_o   = vld_q;
  assign real_q_o  = real_q;
  assign sig_q_o   = sig_q;
  assign done_o    = done_q;
  assign pass_o    = pass_q;
  assign code_o    = code_q;

endmodule

// File: rtl/rc_bound_pick.sv
module rc_bound_pick #(
  parameter int MAXB  = 66,
  parameter int LEN_W = 7
) (
  input  logic [MAXB*8-1:0] p_val,
  input  logic [MAXB*8-1:0] n_val,
  input  logic [LEN_W-1:0]  p_len,
  input  logic [LEN_W-1:0]  n_len,
  input  logic              use_n,
  input  logic [LEN_W-1:0]  sig_i,
  output logic [7:0]        byte_o
);

  logic [7:0] p_bytes [MAXB];
  logic [7:0] n_bytes [MAXB];

  for (genvar g = 0; g < MAXB; g++) begin : g_split
    assign p_bytes[g] = p_val[g*8 +: 8];
    assign n_bytes[g] = n_val[g*8 +: 8];
  end

  logic [LEN_W-1:0] len_sel;
  logic             beyond;

  assign len_sel = use_n ? n_len : p_len;
  assign beyond  = (sig_i >= len_sel) || (int'(sig_i) >= MAXB);

  always_comb begin
    if (beyond)     byte_o = 8'h00;
    else if (use_n) byte_o = n_bytes[sig_i];
    else            byte_o = p_bytes[sig_i];
  end

endmodule

// File: rtl/rc_byte_cmp.sv
module rc_byte_cmp
  import rc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       vld,
  input  logic [7:0] op_byte,
  input  logic [7:0] bnd_byte,
  input  logic       need_nz,
  output logic       ok_o
);

  logic dec_q, lt_q, nz_q;
  logic dec_n, lt_n, nz_n;

  always_comb begin
    dec_n = dec_q || (vld && (op_byte != bnd_byte));
    lt_n  = dec_q ? lt_q : (vld && (op_byte < bnd_byte));
    nz_n  = nz_q || (vld && (op_byte != 8'h00));
  end

  assign ok_o = rc_accept(lt_n, nz_n, need_nz);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      dec_q <= 1'b0;
      lt_q  <= 1'b0;
      nz_q  <= 1'b0;
    end else begin
      dec_q <= dec_n;
      lt_q  <= lt_n;
      nz_q  <= nz_n;
    end
  end

endmodule

// File: rtl/bigint_range_checker.sv
module bigint_range_checker
  import rc_pkg::*;
#(
  parameter int MAXB   = 66,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = $clog2(MAXB + 1),
  parameter int BITS_W = $clog2(MAXB * 8 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] x_base,
  input  logic [LEN_W-1:0]  x_len,
  input  logic [ADDR_W-1:0] y_base,
  input  logic [LEN_W-1:0]  y_len,
  input  logic [ADDR_W-1:0] r_base,
  input  logic [LEN_W-1:0]  r_len,
  input  logic [ADDR_W-1:0] s_base,
  input  logic [LEN_W-1:0]  s_len,
  input  logic [BITS_W-1:0] p_bits,
  input  logic [BITS_W-1:0] n_bits,
  input  logic [MAXB*8-1:0] p_val,
  input  logic [MAXB*8-1:0] n_val,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [1:0]        fail_code
);

  logic [LEN_W-1:0]        p_blen, n_blen;
  logic [3:0][ADDR_W-1:0]  base_a;
  logic [3:0][LEN_W-1:0]   len_a, span_a;

  assign p_blen = LEN_W'(rc_bytes_of_bits(int'(p_bits)));
  assign n_blen = LEN_W'(rc_bytes_of_bits(int'(n_bits)));
  assign base_a = {s_base, r_base, y_base, x_base};
  assign len_a  = {s_len, r_len, y_len, x_len};

  for (genvar k = 0; k < 4; k++) begin : g_span
    localparam bit BOUND_IS_N = (k >= 2);
    assign span_a[k] = LEN_W'(rc_span(int'(len_a[k]), int'(BOUND_IS_N ? n_blen : p_blen)));
  end

  logic             verdict_w, vld_w, real_w, ok_w;
  logic [1:0]       chk_w;
  logic [LEN_W-1:0] sig_w;
  logic [7:0]       op_byte_w, bnd_byte_w;

  rc_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .base_i    (base_a),
    .len_i     (len_a),
    .span_i    (span_a),
    .ok_i      (ok_w),
    .busy_o    (busy),
    .verdict_o (verdict_w),
    .chk_o     (chk_w),
    .rd_en_o   (mem_rd_en),
    .rd_addr_o (mem_rd_addr),
    .vld_q_o   (vld_w),
    .real_q_o  (real_w),
    .sig_q_o   (sig_w),
    .done_o    (done),
    .pass_o    (pass),
    .code_o    (fail_code)
  );

  rc_bound_pick #(.MAXB(MAXB), .LEN_W(LEN_W)) u_bound (
    .p_val  (p_val),
    .n_val  (n_val),
    .p_len  (p_blen),
    .n_len  (n_blen),
    .use_n  (chk_w[1]),
    .sig_i  (sig_w),
    .byte_o (bnd_byte_w)
  );

  // Bytes beyond the operand's own length were not read: they count as zero.
  assign op_byte_w = real_w ? mem_rd_data : 8'h00;

  rc_byte_cmp u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (verdict_w),
    .vld      (vld_w),
    .op_byte  (op_byte_w),
    .bnd_byte (bnd_byte_w),
    .need_nz  (chk_w[1]),
    .ok_o     (ok_w)
  );

endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
  parameter int MAXB   = 66,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   done,
  input logic                   pass,
  input logic [1:0]             fail_code,
  input logic                   mem_rd_en,
  input logic [ADDR_W-1:0]      mem_rd_addr,
  input logic [3:0][ADDR_W-1:0] base_a,
  input logic [3:0][LEN_W-1:0]  len_a,
  input logic [1:0]             chk_w
);

  localparam int RUN_LIMIT = 4 * (MAXB + 1);

  logic [15:0] busy_cyc;
  always_ff @(posedge clk) begin
    if (!rst_n || !busy) busy_cyc <= '0;
    else                 busy_cyc <= busy_cyc + 16'd1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !done && !pass && !mem_rd_en)); // R1

  AST_READ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (busy
      && (int'(mem_rd_addr) >= int'(base_a[chk_w]))
      && (int'(mem_rd_addr) < int'(base_a[chk_w]) + int'(len_a[chk_w])))); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_END_SIGNALLED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R8

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(busy_cyc) < RUN_LIMIT)); // R8

  AST_CHECK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (chk_w >= $past(chk_w))); // R7

  AST_PASS_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pass) |-> (fail_code == 2'd0)); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && !$past(busy)) |-> ($stable(pass) && $stable(fail_code))); // R11

endmodule

bind bigint_range_checker rc_checker #(
  .MAXB   (MAXB),
  .ADDR_W (ADDR_W),
  .LEN_W  (LEN_W)
) u_rc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .pass        (pass),
  .fail_code   (fail_code),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .base_a      (base_a),
  .len_a       (len_a),
  .chk_w       (chk_w)
);

// File: tb/bigint_range_checker_bench.sv
module bigint_range_checker_bench;
  localparam int MAXB   = 66;
  localparam int ADDR_W = 8;
  localparam int LEN_W  = 7;
  localparam int BITS_W = 10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] x_base = 8'd0, y_base = 8'd64, r_base = 8'd128, s_base = 8'd192;
  logic [LEN_W-1:0]  x_len = '0, y_len = '0, r_len = '0, s_len = '0;
  logic [BITS_W-1:0] p_bits = '0, n_bits = '0;
  logic [MAXB*8-1:0] p_vec = '0, n_vec = '0;
  logic              mem_rd_en;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [7:0]        mem_rd_data;
  logic              busy, done, pass;
  logic [1:0]        fail_code;

  bigint_range_checker u_bigint_range_checker (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_base(x_base), .x_len(x_len), .y_base(y_base), .y_len(y_len),
    .r_base(r_base), .r_len(r_len), .s_base(s_base), .s_len(s_len),
    .p_bits(p_bits), .n_bits(n_bits), .p_val(p_vec), .n_val(n_vec),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .busy(busy), .done(done), .pass(pass), .fail_code(fail_code)
  );

  logic [7:0] mem [256];
  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

  int n_reads = 0;
  always @(posedge clk) if (mem_rd_en) n_reads = n_reads + 1;

  int total = 0;
  int bad = 0;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Store a value MSB-first at base.
  task automatic put(input int base, input logic [63:0] val, input int len);
    for (int j = 0; j < len; j++) mem[base + j] = val[(len - 1 - j) * 8 +: 8];
  endtask

  // Reference compare: returns {less, nonzero}.
  function automatic logic [1:0] ref_cmp(input int base, input int len,
                                         input logic [MAXB*8-1:0] vec, input int blen);
    logic lt = 1'b0, dec = 1'b0, nz = 1'b0;
    int top = (len > blen) ? len : blen;
    for (int i = top - 1; i >= 0; i--) begin
      logic [7:0] a, b;
      a = (i < len) ? mem[base + len - 1 - i] : 8'h00;
      b = (i < blen) ? vec[i*8 +: 8] : 8'h00;
      if (!dec && a != b) begin dec = 1'b1; lt = (a < b); end
      if (a != 8'h00) nz = 1'b1;
    end
    return {lt, nz};
  endfunction

  task automatic run(input string tag, input int xl, input int yl, input int rl,
                     input int sl, input int pb, input int nb, input bit poke);
    int lens [4];
    int bases [4];
    int exp_ok, exp_code, exp_cyc, exp_rd, cyc, hold_pass, hold_code;
    lens[0] = xl; lens[1] = yl; lens[2] = rl; lens[3] = sl;
    bases[0] = 0; bases[1] = 64; bases[2] = 128; bases[3] = 192;
    exp_ok = 1; exp_code = 0; exp_cyc = 0; exp_rd = 0;
    for (int k = 0; k < 4; k++) begin
      if (exp_ok == 1) begin
        int bl, sp;
        logic [1:0] rc;
        bl = (k < 2) ? (pb + 7) / 8 : (nb + 7) / 8;
        rc = ref_cmp(bases[k], lens[k], (k < 2) ? p_vec : n_vec, bl);
        sp = (lens[k] > bl) ? lens[k] : bl;
        exp_cyc += sp + 1;
        exp_rd  += lens[k];
        if (!(rc[1] && (k < 2 || rc[0]))) begin exp_ok = 0; exp_code = k; end
      end
    end
    @(negedge clk);
    x_len = LEN_W'(xl); y_len = LEN_W'(yl); r_len = LEN_W'(rl); s_len = LEN_W'(sl);
    p_bits = BITS_W'(pb); n_bits = BITS_W'(nb);
    start = 1'b1;
    n_reads = 0;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 2000) begin
      cyc++;
      start = (poke && (cyc == 2 || cyc == 4)) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check({tag, " R8 done pulse"}, int'(done), 1);
    check({tag, " R8 busy cycles"}, cyc, exp_cyc);
    check({tag, " R7 pass"}, int'(pass), exp_ok);
    check({tag, " R7 fail_code"}, int'(fail_code), exp_code);
    check({tag, " R9 reads"}, n_reads, exp_rd);
    hold_pass = int'(pass); hold_code = int'(fail_code);
    repeat (3) @(negedge clk);
    check({tag, " R11 hold"}, int'(pass) * 4 + int'(fail_code) + int'(busy) * 8,
          hold_pass * 4 + hold_code);
  endtask

  task automatic std_bounds();
    p_vec = '0; p_vec[15:0] = 16'hF00D;
    n_vec = '0; n_vec[15:0] = 16'hBEEF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 rd_en in reset", int'(mem_rd_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", int'(busy) + int'(done) + int'(pass) + int'(mem_rd_en), 0);

    // R5 R6: all in range, Y has a leading zero byte (R3).
    std_bounds();
    put(0, 64'h1234, 2); put(64, 64'h00F00C, 3); put(128, 64'h01, 1); put(192, 64'hBEEE, 2);
    run("D1 R5 R6 R3 all pass", 2, 3, 1, 2, 16, 16, 1'b0);
    run("D1b R10 start while busy", 2, 3, 1, 2, 16, 16, 1'b1);
    // R2: Y equal to p is rejected.
    put(64, 64'hF00D, 2);
    run("D2 R2 equal bound", 2, 2, 1, 2, 16, 16, 1'b0);
    // R6: zero r with bytes, and empty r.
    put(64, 64'h00F00C, 3); put(128, 64'h0000, 2);
    run("D3 R6 zero r", 2, 3, 2, 2, 16, 16, 1'b0);
    run("D4 R6 empty r", 2, 3, 0, 2, 16, 16, 1'b0);
    // R5: empty X is zero and allowed.
    put(128, 64'h01, 1);
    run("D5 R5 zero X", 0, 3, 1, 2, 16, 16, 1'b0);
    // R3: s with nonzero extra high byte is rejected.
    put(192, 64'h01BEEE, 3);
    run("D6 R3 long s", 2, 3, 1, 3, 16, 16, 1'b0);
    // R4: 9-bit p covers 2 bytes, the third vector byte is ignored.
    p_vec = '0; p_vec[23:0] = 24'hFF01FF;
    put(0, 64'h0200, 2);
    run("D7 R4 rounding reject", 2, 3, 1, 2, 9, 16, 1'b0);
    put(0, 64'h01FE, 2); put(64, 64'h0001, 2); put(192, 64'hBEEE, 2);
    run("D8 R4 rounding accept", 2, 2, 1, 2, 9, 16, 1'b0);
    // R2: most significant byte decides despite lower bytes.
    std_bounds();
    put(0, 64'hEFFF, 2); put(64, 64'hF10C, 2);
    run("D9 R2 msb decides", 2, 2, 1, 2, 16, 16, 1'b0);

    for (int t = 0; t < 120; t++) begin
      int xl, yl, rl, sl, pb, nb;
      p_vec = '0; n_vec = '0;
      p_vec[63:0] = {$urandom, $urandom};
      n_vec[63:0] = {$urandom, $urandom};
      pb = 1 + ($urandom % 64); nb = 1 + ($urandom % 64);
      xl = $urandom % 9; yl = $urandom % 9; rl = $urandom % 9; sl = $urandom % 9;
      for (int a = 0; a < 256; a++) begin
        mem[a] = 8'($urandom);
        if (($urandom % 3) == 0) mem[a] = 8'h00;
      end
      run("RND R2 R3 R4 R5 R6 R7", xl, yl, rl, sl, pb, nb, (t % 10) == 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule